// File: doc/BRIEF.md
# Timestamped Cluster Capture Writer

This block is the write side of a logic-capture memory. It takes one 16-bit sample of the input bus every `rate_frac_i + 1` base clocks, groups seven consecutive samples with the timestamp of the first one, and stores each finished group as one 128-bit cluster in a synchronous RAM. Sixty-four clusters form a line of 448 events, which is 1024 bytes. The timestamp counts sample periods.

A pulse on `arm_i` starts a capture and clears all positions. The block keeps a running stop position and latches a trigger position on the first trigger pulse. Two conditions end the capture. The first is that the post-trigger sample count reaches a limit scaled from an 8-bit fraction. The second is that the memory fills. A status byte reports whether the block is capturing and whether the trigger has fired. The stored clusters are read back through a separate synchronous read port.

Top module: `clcap_writer`

## Requirements
- R1: While capturing, exactly one sample is taken every `rate_frac_i + 1` clock cycles, for any 8-bit value 0..255. The first sample is taken `rate_frac_i + 1` cycles after the arm cycle.
- R2: A cluster is written only when its seventh sample is taken, and a partial cluster is never written. Bits [15:0] of a cluster hold the timestamp. Sample j (j = 0..6, in capture order) sits at bits [16*(j+1)+15 : 16*(j+1)].
- R3: The timestamp starts at 0 on arm and advances by one per sample, wrapping modulo 2^16. A cluster's timestamp is the timestamp of its first sample.
- R4: Positions are 24 bits: [23:9] is the line and [8:0] is the event within the line (0..447). The stop position counts only events that have been stored, so it moves in steps of 7 and rolls to the next line after event 441. Cluster c of line L is at RAM address L*64 + c.
- R5: When the line field of the stop position reaches `LINES-1`, capture halts and status bit 0 clears. No further sample changes the stop position.
- R6: The first trigger pulse during a capture latches the index of the sample taken in that cycle into the trigger position and sets status bit 5 (0x20). Later pulses in the same capture are ignored, and so are pulses while idle.
- R7: After the trigger is accepted, exactly floor(`post_frac_i` * (LINES-1) * 448 / 255) further samples are taken, and then capture halts.
- R8: Arm clears the stop position, the trigger position, the trigger flag and the timestamp, and sets status bit 0.
- R9: After reset, both positions and the status byte are zero and nothing is captured.
- R10: The read port returns the cluster at `rd_addr_i` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Pulse: start a fresh capture |
| rate_frac_i | input | 8 | Sample divider; period is value + 1 clocks |
| post_frac_i | input | 8 | Post-trigger length as a fraction of 255 |
| sample_i | input | 16 | Input bus sampled on each sample tick |
| trig_i | input | 1 | Trigger pulse from the trigger logic |
| rd_addr_i | input | $clog2(LINES)+6 | Cluster read address |
| rd_data_o | output | 128 | Cluster read data |
| stop_pos_o | output | 24 | Stored-event position {line, event} |
| trig_pos_o | output | 24 | Latched trigger position {line, event} |
| status_o | output | 8 | Bit 0 capturing, bit 5 trigger fired |

## Verification
The packing path is driven at divider values 0, 2, 5 and 255, each with its own sample pattern. Every stored word can be traced to the base-clock cycle it came from, so a divider off by one shows up as wrong sample values and not only as a wrong count. Free-running captures with no trigger are stopped at points where a cluster is partly filled, which separates stored events from buffered ones. One run crosses a line boundary and continues until memory is full. Trigger runs use post fractions of 0, 3 and 10, with the trigger placed in the first and in the second line. A repeated trigger pulse, a pulse before arm and a pulse after stop each show whether the latch is single-shot and whether the stop condition counts from the right sample.

// File: rtl/clcap_pkg.sv
package clcap_pkg;
  localparam int SAMPLE_W      = 16;
  localparam int CLUSTER_N     = 7;
  localparam int CLUS_PER_LINE = 64;
  localparam int CLUS_AW       = 6;
  localparam int EVT_W         = 9;
  localparam int LINE_W        = 15;
  localparam int POS_W         = LINE_W + EVT_W;
  localparam int EVT_PER_LINE  = CLUSTER_N * CLUS_PER_LINE;
  localparam int CLUSTER_W     = SAMPLE_W * (CLUSTER_N + 1);
  localparam int LAST_EVT      = EVT_PER_LINE - CLUSTER_N;

  // post-trigger sample budget: fraction of the usable event space
  function automatic logic [31:0] scale_limit(input logic [7:0] frac,
                                               input int unsigned usable);
    return (32'(frac) * usable) / 32'd255;
  endfunction

  function automatic logic [POS_W-1:0] make_pos(input logic [LINE_W-1:0] line,
                                                input logic [EVT_W-1:0] evt);
    return {line, evt};
  endfunction
endpackage

// File: rtl/clcap_pacer.sv
module clcap_pacer #(
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              enable,
  input  logic [FRAC_W-1:0] frac,
  output logic              tick
);
  logic [FRAC_W-1:0] cnt_q;

  assign tick = enable && !restart && (cnt_q == frac);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
    end else if (enable) begin
      if (cnt_q == frac) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/clcap_packer.sv
module clcap_packer
  import clcap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 tick,
  input  logic [SAMPLE_W-1:0]  sample,
  input  logic [SAMPLE_W-1:0]  ts,
  output logic                 wr,
  output logic [CLUSTER_W-1:0] wr_data,
  output logic [2:0]           fill
);
  localparam int HOLD_N = CLUSTER_N - 1;

  logic [HOLD_N-1:0][SAMPLE_W-1:0] hold_q;
  logic [SAMPLE_W-1:0]             first_ts_q;
  logic [2:0]                      fill_q;

  assign fill = fill_q;
  assign wr   = tick && (fill_q == 3'(HOLD_N));

  assign wr_data[SAMPLE_W-1:0]                   = first_ts_q;
  assign wr_data[CLUSTER_W-1 -: SAMPLE_W]        = sample;
  for (genvar g = 0; g < HOLD_N; g++) begin : g_slot
    assign wr_data[SAMPLE_W*(g+1) +: SAMPLE_W] = hold_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q     <= '0;
      first_ts_q <= '0;
      hold_q     <= '0;
    end else if (restart) begin
      fill_q <= '0;
    end else if (tick) begin
      if (fill_q == 3'd0) first_ts_q <= ts;
      if (fill_q == 3'(HOLD_N)) begin
        fill_q <= '0;
      end else begin
        hold_q[fill_q] <= sample;
        fill_q         <= fill_q + 3'd1;
      end
    end
  end
endmodule

// File: rtl/clcap_ram.sv
module clcap_ram #(
  parameter int DW    = 128,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/clcap_writer.sv
module clcap_writer
  import clcap_pkg::*;
#(
  parameter int LINES = 4,
  localparam int RAM_AW = $clog2(LINES) + CLUS_AW,
  localparam int USABLE = (LINES - 1) * EVT_PER_LINE,
  localparam int POST_W = $clog2(USABLE + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm_i,
  input  logic [7:0]           rate_frac_i,
  input  logic [7:0]           post_frac_i,
  input  logic [SAMPLE_W-1:0]  sample_i,
  input  logic                 trig_i,
  input  logic [RAM_AW-1:0]    rd_addr_i,
  output logic [CLUSTER_W-1:0] rd_data_o,
  output logic [POS_W-1:0]     stop_pos_o,
  output logic [POS_W-1:0]     trig_pos_o,
  output logic [7:0]           status_o
);
  logic                 run_q, trig_seen_q;
  logic [SAMPLE_W-1:0]  ts_q;
  logic [LINE_W-1:0]    line_q;
  logic [CLUS_AW-1:0]   clus_q;
  logic [EVT_W-1:0]     evt_q;
  logic [POS_W-1:0]     trig_pos_q;
  logic [POST_W-1:0]    post_cnt_q;

  // named internal events, also observed by the bound checker
  logic                 tick, clus_wr, stop_now, full_hit, trig_acc;
  logic [POST_W-1:0]    post_lim;
  logic [2:0]           fill;
  logic [CLUSTER_W-1:0] clus_data;
  logic [RAM_AW-1:0]    wr_addr;

  assign post_lim = POST_W'(scale_limit(post_frac_i, USABLE));
  assign stop_now = trig_seen_q && (post_cnt_q >= post_lim);
  assign full_hit = clus_wr && (clus_q == CLUS_AW'(CLUS_PER_LINE - 1))
                    && (line_q == LINE_W'(LINES - 2));
  assign trig_acc = trig_i && run_q && !trig_seen_q && !arm_i;
  assign wr_addr  = RAM_AW'({line_q, clus_q});

  clcap_pacer #(.FRAC_W(8)) u_pacer (
    .clk(clk), .rst_n(rst_n), .restart(arm_i),
    .enable(run_q && !stop_now), .frac(rate_frac_i), .tick(tick)
  );

  clcap_packer u_packer (
    .clk(clk), .rst_n(rst_n), .restart(arm_i), .tick(tick),
    .sample(sample_i), .ts(ts_q), .wr(clus_wr), .wr_data(clus_data),
    .fill(fill)
  );

  clcap_ram #(.DW(CLUSTER_W), .DEPTH(LINES * CLUS_PER_LINE)) u_ram (
    .clk(clk), .we(clus_wr), .waddr(wr_addr), .wdata(clus_data),
    .raddr(rd_addr_i), .rdata(rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      trig_seen_q <= 1'b0;
      ts_q        <= '0;
      line_q      <= '0;
      clus_q      <= '0;
      evt_q       <= '0;
      trig_pos_q  <= '0;
      post_cnt_q  <= '0;
    end else if (arm_i) begin
      run_q       <= 1'b1;
      trig_seen_q <= 1'b0;
      ts_q        <= '0;
      line_q      <= '0;
      clus_q      <= '0;
      evt_q       <= '0;
      trig_pos_q  <= '0;
      post_cnt_q  <= '0;
    end else begin
      if (tick) begin
        ts_q <= ts_q + 1'b1;
        if (trig_seen_q) post_cnt_q <= post_cnt_q + 1'b1;
      end
      if (clus_wr) begin
        if (evt_q == EVT_W'(LAST_EVT)) begin
          evt_q  <= '0;
          clus_q <= '0;
          line_q <= line_q + 1'b1;
        end else begin
          evt_q  <= evt_q + EVT_W'(CLUSTER_N);
          clus_q <= clus_q + 1'b1;
        end
      end
      if (trig_acc) begin
        trig_seen_q <= 1'b1;
        trig_pos_q  <= make_pos(line_q, evt_q + EVT_W'(fill));
      end
      if (stop_now || full_hit) run_q <= 1'b0;
    end
  end

  assign stop_pos_o = make_pos(line_q, evt_q);
  assign trig_pos_o = trig_pos_q;
  assign status_o   = {2'b00, trig_seen_q, 4'b0000, run_q};
endmodule

// File: rtl/clcap_writer_chk.sv
module clcap_writer_chk
  import clcap_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int POST_W = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arm_i,
  input logic [7:0]         rate_frac_i,
  input logic [POS_W-1:0]   stop_pos_o,
  input logic [POS_W-1:0]   trig_pos_o,
  input logic [7:0]         status_o,
  input logic               tick,
  input logic               clus_wr,
  input logic [SAMPLE_W-1:0] ts_q,
  input logic               trig_seen_q,
  input logic [POST_W-1:0]  post_cnt_q,
  input logic [POST_W-1:0]  post_lim
);
  logic [8:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n || arm_i || tick) gap_q <= '0;
    else if (status_o[0])        gap_q <= gap_q + 9'd1;
  end

  p_rate_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !arm_i) |-> (gap_q == {1'b0, rate_frac_i}));

  p_write_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clus_wr && !arm_i) |=> (stop_pos_o != $past(stop_pos_o)));

  p_ts_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !arm_i) |=> (ts_q == $past(ts_q) + 16'd1));

  p_evt_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pos_o[8:0] < 9'd448) && ((stop_pos_o[8:0] % 9'd7) == 9'd0));

  p_full_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pos_o[23:9] == 15'(LINES - 1)) |-> !status_o[0]);

  p_trig_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_seen_q && !arm_i) |=> $stable(trig_pos_o));

  p_post_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[0] && trig_seen_q) |-> (post_cnt_q <= post_lim));

  p_arm_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (stop_pos_o == '0 && trig_pos_o == '0 && status_o == 8'h01));
endmodule

bind clcap_writer clcap_writer_chk #(.LINES(LINES), .POST_W(POST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .rate_frac_i(rate_frac_i),
  .stop_pos_o(stop_pos_o), .trig_pos_o(trig_pos_o), .status_o(status_o),
  .tick(tick), .clus_wr(clus_wr), .ts_q(ts_q), .trig_seen_q(trig_seen_q),
  .post_cnt_q(post_cnt_q), .post_lim(post_lim)
);

// File: tb/clcap_writer_bench.sv
module clcap_writer_bench;
  localparam int LINES  = 4;
  localparam int USABLE = (LINES - 1) * 448;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         arm = 1'b0;
  logic [7:0]   rate = '0;
  logic [7:0]   postf = '0;
  logic [15:0]  smp = '0;
  logic         trig = 1'b0;
  logic [7:0]   rd_addr = '0;
  logic [127:0] rd_data;
  logic [23:0]  stop_pos, trig_pos;
  logic [7:0]   status;

  int n_chk = 0, n_fail = 0;
  int k = 0, ta = -1, tb = -1;
  logic [15:0] seed = 16'h4000;
  bit done = 1'b0;

  clcap_writer #(.LINES(LINES)) u_clcap_writer (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .rate_frac_i(rate),
    .post_frac_i(postf), .sample_i(smp), .trig_i(trig), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .stop_pos_o(stop_pos), .trig_pos_o(trig_pos),
    .status_o(status)
  );

  always #4 clk = ~clk;

  // stimulus rows: {divider, pattern seed, steps}
  localparam logic [39:0] VEC [4] = '{
    {8'd0,   16'h1000, 16'd31},
    {8'd2,   16'h2000, 16'd61},
    {8'd5,   16'hA5A5, 16'd101},
    {8'd255, 16'h0300, 16'd2049}
  };

  function automatic logic [15:0] pat(input int kk);
    return seed + 16'(kk) * 16'h0101;
  endfunction

  function automatic logic [23:0] pos_of(input int n);
    return {15'(n / 448), 9'(n % 448)};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one negedge: drive the inputs for the next edge
  task automatic step();
    @(negedge clk);
    arm  = 1'b0;
    smp  = pat(k);
    trig = (k == ta) || (k == tb);
    k++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_arm(input logic [7:0] fr, input logic [7:0] pf);
    @(negedge clk);
    rate = fr; postf = pf; arm = 1'b1; trig = 1'b0; k = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [127:0] d);
    rd_addr = a;
    step();
    d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [127:0] d, e;
    int fr, ns, smpls, stored, total;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(status == 8'h00, "R9 status", 128'(status), 0);
    check(stop_pos == 24'h0, "R9 stop_pos", 128'(stop_pos), 0);
    check(trig_pos == 24'h0, "R9 trig_pos", 128'(trig_pos), 0);
    // R6: trigger while idle is ignored
    k = 0; ta = 1; tb = -1;
    run(4);
    check(status == 8'h00, "R6 idle trigger status", 128'(status), 0);
    check(trig_pos == 24'h0, "R6 idle trigger pos", 128'(trig_pos), 0);
    ta = -1;

    // table: R1 R2 R3 R4 R10 under several divider values and patterns
    for (int v = 0; v < 4; v++) begin
      fr = int'(VEC[v][39:32]);
      seed = VEC[v][31:16];
      ns = int'(VEC[v][15:0]);
      do_arm(VEC[v][39:32], 8'd255);
      run(ns);
      smpls = (ns - 1) / (fr + 1);
      stored = (smpls / 7) * 7;
      check(stop_pos == pos_of(stored), "R4 stop position", 128'(stop_pos),
            128'(pos_of(stored)));
      rd(8'd0, d);
      e = '0;
      for (int j = 0; j < 7; j++) e[16*(j+1) +: 16] = pat((fr + 1) * (j + 1) - 1);
      check(d == e, "R1 R2 R3 R10 cluster 0 content", d, e);
      if (stored >= 14) begin
        rd(8'd1, d);
        check(d[15:0] == 16'd7, "R3 cluster 1 timestamp", 128'(d[15:0]), 7);
      end
    end

    // R8: re-arm after a trigger clears everything
    seed = 16'h4000;
    ta = 3; tb = -1;
    do_arm(8'd0, 8'd255);
    run(10);
    check(status == 8'h21, "R6 trigger flag set", 128'(status), 128'h21);
    ta = -1;
    do_arm(8'd0, 8'd255);
    run(1);
    check(status == 8'h01, "R8 status after arm", 128'(status), 128'h01);
    check(trig_pos == 24'h0, "R8 trig_pos cleared", 128'(trig_pos), 0);
    check(stop_pos == 24'h0, "R8 stop_pos cleared", 128'(stop_pos), 0);

    // R6 R7: trigger at 20, second pulse at 40, post fraction 10
    ta = 20; tb = 40;
    do_arm(8'd0, 8'd10);
    run(200);
    total = 20 + 1 + (10 * USABLE) / 255;
    check(trig_pos == pos_of(20), "R6 trigger position", 128'(trig_pos),
          128'(pos_of(20)));
    check(status == 8'h20, "R7 stopped after post limit", 128'(status), 128'h20);
    check(stop_pos == pos_of((total / 7) * 7), "R7 stop after trigger",
          128'(stop_pos), 128'(pos_of((total / 7) * 7)));

    // R7: post fraction 0
    ta = 10; tb = -1;
    do_arm(8'd0, 8'd0);
    run(60);
    check(stop_pos == pos_of(7), "R7 zero post limit", 128'(stop_pos),
          128'(pos_of(7)));
    check(status == 8'h20, "R7 zero post status", 128'(status), 128'h20);

    // R4 R6 R7: trigger in second line, post fraction 3
    ta = 460; tb = -1;
    do_arm(8'd0, 8'd3);
    run(600);
    total = 460 + 1 + (3 * USABLE) / 255;
    check(trig_pos == pos_of(460), "R4 trigger position line 1", 128'(trig_pos),
          128'(pos_of(460)));
    check(stop_pos == pos_of((total / 7) * 7), "R7 stop in line 1",
          128'(stop_pos), 128'(pos_of((total / 7) * 7)));

    // R4 R5: line rollover then memory full
    ta = -1; tb = -1;
    do_arm(8'd0, 8'd255);
    run(451);
    check(stop_pos == 24'h000200, "R4 line rollover", 128'(stop_pos), 128'h200);
    run(1000);
    check(stop_pos == pos_of(USABLE), "R5 full stop position", 128'(stop_pos),
          128'(pos_of(USABLE)));
    check(status == 8'h00, "R5 full status", 128'(status), 0);
    rd(8'd191, d);
    e = '0;
    e[15:0] = 16'(USABLE - 7);
    for (int j = 0; j < 7; j++) e[16*(j+1) +: 16] = pat(USABLE - 7 + j);
    check(d == e, "R2 R4 last cluster", d, e);
    // R6: trigger after stop ignored
    ta = k; tb = -1;
    run(20);
    check(status == 8'h00, "R6 trigger after stop", 128'(status), 0);
    check(trig_pos == 24'h0, "R6 trig_pos after stop", 128'(trig_pos), 0);
    check(stop_pos == pos_of(USABLE), "R5 stop position frozen", 128'(stop_pos),
          128'(pos_of(USABLE)));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule